// File: doc/BRIEF.md
# Open-Drain Serial Transmitter with Line Turnaround

This block sends bytes as 8N1 serial frames on a shared wire that is pulled up. It never drives the wire high. It only switches a low-side driver on and off: a one bit leaves the wire released, and a zero bit or a start bit pulls it low. Bytes come in through a valid/ready push port and wait in a small FIFO. All bit timing follows an enable tick at eight times the baud rate.

In full-duplex mode the transmitter has its own pin. It is always enabled and the companion receiver is never switched off. In half-duplex mode the two share one wire. The block waits until the receiver reports the line idle, then takes the line. It sends every queued byte, keeps the line for a guard time after the last data bit, and then gives direction back to the receiver. The mode input must only change while the block is not busy.

Top module: `od_uart_tx`

## Requirements
- R1: After reset, drive_low_o is 0, rx_enable_o is 1, busy_o is 0 and tx_ready_o is 1.
- R2: A frame is a start bit with drive_low_o at 1 for exactly 8 ticks, then 8 data bits sent least significant bit first, each lasting 8 ticks. A data bit of 1 gives drive_low_o = 0 and a data bit of 0 gives drive_low_o = 1. drive_low_o changes only on a clock edge where tick_i is high.
- R3: Before each byte is taken from the FIFO, the line is released for at least 8 ticks. This time is the stop bit. When bytes are queued back to back, consecutive start bits begin exactly 80 ticks apart.
- R4: tx_ready_o is 0 while FIFO_DEPTH bytes are queued. A push offered while tx_ready_o is 0 is dropped. Accepted bytes are sent in the order they were pushed.
- R5: In half-duplex mode (half_duplex_i = 1), while line_idle_i is 0 and the receiver owns the line, nothing is sent. rx_enable_o stays 1 and drive_low_o stays 0. drive_low_o is never 1 while rx_enable_o is 1.
- R6: In half-duplex mode, the line is taken in the cycle after one in which a byte is queued and line_idle_i is 1. From that cycle on, rx_enable_o is 0 and busy_o is 1.
- R7: In half-duplex mode, once the FIFO is empty and the last data bit has ended, rx_enable_o returns to 1 and busy_o falls exactly GUARD_BITS*8 ticks (88 by default) after the end of that data bit. The stop bit counts as part of this time.
- R8: In full-duplex mode, rx_enable_o stays 1 at all times and no turnaround takes place. busy_o is 1 while a frame is in progress or a byte is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable pulse at 8x the baud rate |
| half_duplex_i | input | 1 | 1 selects shared-wire half-duplex mode |
| tx_data_i | input | DATA_W | Byte to queue |
| tx_valid_i | input | 1 | Push request |
| tx_ready_o | output | 1 | FIFO can accept a byte |
| line_idle_i | input | 1 | Receiver reports the shared line idle |
| rx_enable_o | output | 1 | Receiver owns the line and is enabled |
| drive_low_o | output | 1 | Enable for the low driver; 0 releases the line |
| busy_o | output | 1 | Transmitter holds the line or has work pending |

## Verification
The assertions check the direction rules on every cycle. In half-duplex mode the line is never driven while the receiver is enabled, busy_o is high whenever the transmitter owns the line, and a takeover only follows a cycle in which the line was idle. In full-duplex mode the receiver is never disabled, and the driver enable never moves without a tick. Some properties are only shown by the bench scenarios: exact bit lengths and bit order, the 80-tick spacing of back-to-back frames, the exact 88-tick guard, the dropping of pushes into a full queue, and the order in which queued bytes come out.

// File: rtl/odtx_pkg.sv
package odtx_pkg;
  typedef enum logic [1:0] {SH_REST, SH_START, SH_DATA} sh_state_e;
  typedef enum logic {DIR_RX, DIR_TX} dir_state_e;
endpackage

// File: rtl/odtx_fifo.sv
module odtx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;

  assign empty_o = (wr_ptr == rd_ptr);
  assign full_o  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign data_o  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[wr_ptr[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_i && !full_o) wr_ptr <= wr_ptr + 1'b1;
      if (pop_i && !empty_o) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/odtx_shifter.sv
module odtx_shifter
  import odtx_pkg::*;
#(
  parameter int W   = 8,
  parameter int TPB = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         avail_i,
  input  logic [W-1:0] data_i,
  output logic         pop_o,
  output logic         drive_low_o,
  output logic         framing_o
);
  localparam int CW = $clog2(TPB);
  localparam int BW = $clog2(W);

  sh_state_e     state;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic [W-1:0]  shreg;
  logic          tcnt_last;

  assign tcnt_last   = (tcnt == CW'(TPB - 1));
  // rest counter saturates at TPB-1: the fetch tick completes the stop bit
  assign pop_o       = tick_i && en_i && avail_i && (state == SH_REST) && tcnt_last;
  assign drive_low_o = (state == SH_START) || ((state == SH_DATA) && !shreg[0]);
  assign framing_o   = (state != SH_REST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= SH_REST;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
    end else if (tick_i) begin
      unique case (state)
        SH_REST: begin
          if (pop_o) begin
            state <= SH_START;
            tcnt  <= '0;
            shreg <= data_i;
          end else if (!tcnt_last) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        SH_START: begin
          if (tcnt_last) begin
            state <= SH_DATA;
            tcnt  <= '0;
            bidx  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        SH_DATA: begin
          if (tcnt_last) begin
            tcnt  <= '0;
            shreg <= shreg >> 1;
            if (bidx == BW'(W - 1)) state <= SH_REST;
            else                    bidx  <= bidx + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= SH_REST;
      endcase
    end
  end
endmodule

// File: rtl/odtx_dir.sv
module odtx_dir
  import odtx_pkg::*;
#(
  parameter int GUARD_TICKS = 88
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic half_i,
  input  logic pending_i,
  input  logic line_idle_i,
  input  logic framing_i,
  output logic tx_en_o,
  output logic rx_enable_o,
  output logic busy_o
);
  localparam int GW = $clog2(GUARD_TICKS);

  dir_state_e    state;
  logic [GW-1:0] gcnt;

  assign tx_en_o     = !half_i || (state == DIR_TX);
  assign rx_enable_o = !half_i || (state == DIR_RX);
  assign busy_o      = half_i ? (state == DIR_TX) : (pending_i || framing_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= DIR_RX;
      gcnt  <= '0;
    end else if (!half_i) begin
      state <= DIR_RX;
      gcnt  <= '0;
    end else begin
      unique case (state)
        DIR_RX: begin
          gcnt <= '0;
          if (pending_i && line_idle_i) state <= DIR_TX;
        end
        DIR_TX: begin
          // guard restarts whenever there is more to send
          if (pending_i || framing_i) begin
            gcnt <= '0;
          end else if (tick_i) begin
            if (gcnt == GW'(GUARD_TICKS - 1)) begin
              state <= DIR_RX;
              gcnt  <= '0;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
        end
        default: state <= DIR_RX;
      endcase
    end
  end
endmodule

// File: rtl/od_uart_tx.sv
module od_uart_tx #(
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 4,
  parameter int TICKS_PER_BIT = 8,
  parameter int GUARD_BITS    = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              half_duplex_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic              line_idle_i,
  output logic              rx_enable_o,
  output logic              drive_low_o,
  output logic              busy_o
);
  localparam int GUARD_TICKS = GUARD_BITS * TICKS_PER_BIT;

  logic [DATA_W-1:0] q_data;
  logic              q_empty, q_full, pop, framing, tx_en;

  assign tx_ready_o = !q_full;

  odtx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_valid_i),
    .data_i  (tx_data_i),
    .pop_i   (pop),
    .data_o  (q_data),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  odtx_shifter #(.W(DATA_W), .TPB(TICKS_PER_BIT)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .en_i        (tx_en),
    .avail_i     (!q_empty),
    .data_i      (q_data),
    .pop_o       (pop),
    .drive_low_o (drive_low_o),
    .framing_o   (framing)
  );

  odtx_dir #(.GUARD_TICKS(GUARD_TICKS)) u_dir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .half_i      (half_duplex_i),
    .pending_i   (!q_empty),
    .line_idle_i (line_idle_i),
    .framing_i   (framing),
    .tx_en_o     (tx_en),
    .rx_enable_o (rx_enable_o),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/od_uart_tx_chk.sv
module od_uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic half_duplex_i,
  input logic line_idle_i,
  input logic rx_enable_o,
  input logic drive_low_o,
  input logic busy_o
);
  p_tick_paced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(drive_low_o));

  p_hd_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_duplex_i && rx_enable_o) |-> !drive_low_o);

  p_take_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_duplex_i && $fell(rx_enable_o)) |-> $past(line_idle_i));

  p_own_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_duplex_i && !rx_enable_o) |-> busy_o);

  p_fd_rx_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_duplex_i |-> rx_enable_o);
endmodule

bind od_uart_tx od_uart_tx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .half_duplex_i (half_duplex_i),
  .line_idle_i   (line_idle_i),
  .rx_enable_o   (rx_enable_o),
  .drive_low_o   (drive_low_o),
  .busy_o        (busy_o)
);

// File: tb/od_uart_tx_test.sv
module od_uart_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       half = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       line_idle = 1'b0;
  logic       tx_ready, rx_enable, drive_low, busy;
  int         tick_no = 0;
  int         n_checks = 0;
  int         n_errors = 0;

  always #4 clk = ~clk;

  od_uart_tx uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (tick),
    .half_duplex_i (half),
    .tx_data_i     (tx_data),
    .tx_valid_i    (tx_valid),
    .tx_ready_o    (tx_ready),
    .line_idle_i   (line_idle),
    .rx_enable_o   (rx_enable),
    .drive_low_o   (drive_low),
    .busy_o        (busy)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  always @(posedge clk) if (rst_n && tick) tick_no <= tick_no + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int target);
    while (tick_no < target) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic capture(input logic [7:0] exp, input bit fd, output int t0);
    while (!drive_low) @(negedge clk);
    t0 = tick_no;
    wait_tick(t0 + 7);
    chk("R2 start held 8 ticks", int'(drive_low), 1);
    wait_tick(t0 + 8);
    chk("R2 start ends at tick 8", int'(drive_low), int'(!exp[0]));
    for (int k = 0; k < 8; k++) begin
      wait_tick(t0 + 12 + 8 * k);
      chk($sformatf("R2 data bit %0d lsb first", k), int'(drive_low), int'(!exp[k]));
      if (k == 3) begin
        chk("R8/R6 busy mid frame", int'(busy), 1);
        chk(fd ? "R8 rx enabled in full duplex" : "R6 rx disabled while sending",
            int'(rx_enable), fd ? 1 : 0);
      end
    end
    wait_tick(t0 + 76);
    chk("R3 stop bit released", int'(drive_low), 0);
  endtask

  task automatic test_reset();
    chk("R1 drive_low after reset", int'(drive_low), 0);
    chk("R1 rx_enable after reset", int'(rx_enable), 1);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 tx_ready after reset", int'(tx_ready), 1);
  endtask

  task automatic test_fd_single();
    int t0;
    half = 1'b0;
    fork push(8'hA5); join_none
    capture(8'hA5, 1'b1, t0);
    chk("R8 busy after frame ends", int'(busy), 0);
    chk("R8 rx stays enabled", int'(rx_enable), 1);
  endtask

  task automatic test_back_to_back();
    int t0, t1;
    fork begin push(8'h3C); push(8'hC3); end join_none
    capture(8'h3C, 1'b1, t0);
    capture(8'hC3, 1'b1, t1);
    chk("R3 back-to-back spacing 80 ticks", t1 - t0, 80);
  endtask

  task automatic test_hd_turnaround();
    int t0;
    half = 1'b1;
    line_idle = 1'b0;
    push(8'h5A);
    wait_tick(tick_no + 40);
    chk("R5 no drive while line busy", int'(drive_low), 0);
    chk("R5 rx kept enabled", int'(rx_enable), 1);
    chk("R5 not busy while waiting", int'(busy), 0);
    @(negedge clk);
    line_idle = 1'b1;
    @(negedge clk);
    chk("R6 rx disabled after take", int'(rx_enable), 0);
    chk("R6 busy after take", int'(busy), 1);
    capture(8'h5A, 1'b0, t0);
    wait_tick(t0 + 159);
    chk("R7 line still held before guard end", int'(rx_enable), 0);
    chk("R7 busy before guard end", int'(busy), 1);
    wait_tick(t0 + 160);
    chk("R7 rx back at guard end", int'(rx_enable), 1);
    chk("R7 busy low at guard end", int'(busy), 0);
    line_idle = 1'b0;
  endtask

  task automatic test_fifo_full();
    int t0;
    int rises;
    logic prev;
    logic [7:0] seq [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    half = 1'b1;
    line_idle = 1'b0;
    for (int i = 0; i < 4; i++) push(seq[i]);
    @(negedge clk);
    chk("R4 ready low when full", int'(tx_ready), 0);
    tx_data  = 8'hEE;
    tx_valid = 1'b1;
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    chk("R4 still full after dropped push", int'(tx_ready), 0);
    line_idle = 1'b1;
    for (int i = 0; i < 4; i++) capture(seq[i], 1'b0, t0);
    wait_tick(t0 + 161);
    chk("R4 queue drained and ready", int'(tx_ready), 1);
    chk("R7 released after last frame", int'(rx_enable), 1);
    rises = 0;
    prev  = drive_low;
    while (tick_no < t0 + 300) begin
      @(negedge clk);
      if (drive_low && !prev) rises++;
      prev = drive_low;
    end
    chk("R4 dropped byte never sent", rises, 0);
    line_idle = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fd_single();
    test_back_to_back();
    test_hd_turnaround();
    test_fifo_full();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule